// File: doc/BRIEF.md
# Serial FIFO DMA Request Generator

This block sits beside the transmit and receive FIFOs of a serial peripheral and turns their occupancy counts into DMA request lines. Each direction gets two lines. The single line asks the DMA engine to move one item. The burst line asks it to move a group of items.

On the transmit side, the single line is raised while at least one slot is free. The burst line is raised once the free space reaches a trigger level. On the receive side, the single line is raised while at least one entry is held. The burst line is raised once the fill count reaches the trigger level.

A build parameter picks how the trigger level is set. In one variant it comes from a per-direction select input. In the other it is pinned at four entries. Each direction also has its own enable. The FIFOs themselves, the serial engine and the DMA engine are outside this block.

There is no data stream through the block. The counts, enables and selects are plain control inputs and the requests are plain level outputs, so no valid/ready handshake and no back-pressure apply.

Top module: `dmareq_top`

## Requirements
- R1: While rst_n is low, all four request outputs are 0, whatever the inputs are.
- R2: Every request output is registered. A change on any input shows up on the outputs after the next rising clock edge and not before it.
- R3: With the transmit enable set, tx_single_req is 1 exactly when the transmit count is below DEPTH.
- R4: With the receive enable set, rx_single_req is 1 exactly when the receive count is non-zero.
- R5: With the transmit enable set, tx_burst_req is 1 exactly when the free space (DEPTH minus the transmit count) is greater than or equal to the transmit trigger level.
- R6: With the receive enable set, rx_burst_req is 1 exactly when the receive count is greater than or equal to the receive trigger level.
- R7: In the configurable variant (FIXED_LEVEL=0), the 3-bit select maps to a trigger level as follows, shown for DEPTH=16: 0 gives DEPTH/8 (2), 1 gives DEPTH/4 (4), 2 gives DEPTH/2 (8), 3 gives 3*DEPTH/4 (12) and 4 gives 7*DEPTH/8 (14). Codes 5, 6 and 7 act like code 4.
- R8: In the fixed variant (FIXED_LEVEL=1), the trigger level is 4 for both directions and the select inputs have no effect.
- R9: When a direction's enable is 0, both request outputs of that direction are 0 one cycle later. The other direction is unaffected.
- R10: A count above DEPTH is treated as DEPTH. The transmit side then sees a full FIFO, and the receive side sees a full FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_count | input | CW = $clog2(DEPTH)+1 | Entries held in the transmit FIFO |
| rx_count | input | CW | Entries held in the receive FIFO |
| tx_dma_en | input | 1 | Transmit request enable |
| rx_dma_en | input | 1 | Receive request enable |
| tx_trig_sel | input | 3 | Transmit trigger level select (configurable variant) |
| rx_trig_sel | input | 3 | Receive trigger level select (configurable variant) |
| tx_single_req | output | 1 | Transmit single request |
| tx_burst_req | output | 1 | Transmit burst request |
| rx_single_req | output | 1 | Receive single request |
| rx_burst_req | output | 1 | Receive burst request |

## Verification
The hardest states to reach sit exactly on a burst boundary: free space or fill equal to the trigger level, and one entry short of it. They have to be reached for every select code, including the codes that saturate to the top level.

The stimulus table places the counts at the level and at level minus one for each code, on both sides at once. It also drives counts beyond DEPTH to reach the clamp.

A second instance built as the fixed variant sees the same inputs. A select that would move the configurable level therefore leaves the fixed outputs unchanged. That difference is compared directly.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    TRIG_EIGHTH  = 3'd0,
    TRIG_QUARTER = 3'd1,
    TRIG_HALF    = 3'd2,
    TRIG_3QUART  = 3'd3,
    TRIG_7EIGHTH = 3'd4
  } trig_sel_e;

  // Trigger level in eighths of the FIFO depth for a select code.
  function automatic int unsigned sel_eighths(logic [SEL_W-1:0] sel);
    case (sel)
      TRIG_EIGHTH:  return 1;
      TRIG_QUARTER: return 2;
      TRIG_HALF:    return 4;
      TRIG_3QUART:  return 6;
      default:      return 7;
    endcase
  endfunction
endpackage

// File: rtl/dmareq_level.sv
module dmareq_level
  import dmareq_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter bit          FIXED_LEVEL = 1'b0,
  parameter int unsigned FIXED_VAL   = 4,
  localparam int unsigned CW         = $clog2(DEPTH) + 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CW-1:0]    level
);
  generate
    if (FIXED_LEVEL) begin : g_fixed
      logic unused_sel;
      assign unused_sel = ^sel;
      assign level      = CW'(FIXED_VAL);
    end else begin : g_cfg
      always_comb begin
        level = CW'((DEPTH * sel_eighths(sel)) / 8);
      end
    end
  endgenerate
endmodule

// File: rtl/dmareq_dir.sv
module dmareq_dir #(
  parameter int unsigned DEPTH = 16,
  parameter bit          IS_TX = 1'b1,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  output logic          single_q,
  output logic          burst_q
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_c;
  logic [CW-1:0] metric;
  logic          single_d;
  logic          burst_d;

  assign cnt_c = (count > FULL) ? FULL : count;

  generate
    if (IS_TX) begin : g_tx
      assign single_d = cnt_c < FULL;
      assign metric   = FULL - cnt_c;
    end else begin : g_rx
      assign single_d = cnt_c != '0;
      assign metric   = cnt_c;
    end
  endgenerate

  assign burst_d = metric >= level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      burst_q  <= 1'b0;
    end else begin
      single_q <= en & single_d;
      burst_q  <= en & burst_d;
    end
  end
endmodule

// File: rtl/dmareq_top.sv
module dmareq_top
  import dmareq_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter bit          FIXED_LEVEL = 1'b0,
  localparam int unsigned CW         = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    tx_count,
  input  logic [CW-1:0]    rx_count,
  input  logic             tx_dma_en,
  input  logic             rx_dma_en,
  input  logic [SEL_W-1:0] tx_trig_sel,
  input  logic [SEL_W-1:0] rx_trig_sel,
  output logic             tx_single_req,
  output logic             tx_burst_req,
  output logic             rx_single_req,
  output logic             rx_burst_req
);
  logic [CW-1:0] tx_level;
  logic [CW-1:0] rx_level;

  dmareq_level #(.DEPTH(DEPTH), .FIXED_LEVEL(FIXED_LEVEL)) u_tx_lvl (
    .sel   (tx_trig_sel),
    .level (tx_level)
  );

  dmareq_level #(.DEPTH(DEPTH), .FIXED_LEVEL(FIXED_LEVEL)) u_rx_lvl (
    .sel   (rx_trig_sel),
    .level (rx_level)
  );

  dmareq_dir #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tx_dma_en),
    .count    (tx_count),
    .level    (tx_level),
    .single_q (tx_single_req),
    .burst_q  (tx_burst_req)
  );

  dmareq_dir #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_dma_en),
    .count    (rx_count),
    .level    (rx_level),
    .single_q (rx_single_req),
    .burst_q  (rx_burst_req)
  );
endmodule

// File: rtl/dmareq_chk.sv
module dmareq_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_dma_en,
  input logic          rx_dma_en,
  input logic          tx_single_req,
  input logic          tx_burst_req,
  input logic          rx_single_req,
  input logic          rx_burst_req
);
  // R3
  tx_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_en && tx_count < CW'(DEPTH)) |=> tx_single_req);

  // R4
  rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> !rx_single_req);

  // R5
  tx_burst_has_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_burst_req |-> tx_single_req);

  // R6
  rx_burst_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_burst_req |-> rx_single_req);

  // R9
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dma_en |=> (!tx_single_req && !tx_burst_req));

  // R9
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dma_en |=> (!rx_single_req && !rx_burst_req));

  // R10
  tx_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count >= CW'(DEPTH)) |=> (!tx_single_req && !tx_burst_req));
endmodule

bind dmareq_top dmareq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_count      (tx_count),
  .rx_count      (rx_count),
  .tx_dma_en     (tx_dma_en),
  .rx_dma_en     (rx_dma_en),
  .tx_single_req (tx_single_req),
  .tx_burst_req  (tx_burst_req),
  .rx_single_req (rx_single_req),
  .rx_burst_req  (rx_burst_req)
);

// File: tb/dmareq_top_tb.sv
module dmareq_top_tb;
  localparam int NV = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] tx_count = '0;
  logic [4:0] rx_count = '0;
  logic       tx_dma_en = 1'b0;
  logic       rx_dma_en = 1'b0;
  logic [2:0] tx_trig_sel = '0;
  logic [2:0] rx_trig_sel = '0;
  logic ts, tb, rs, rb;
  logic fts, ftb, frs, frb;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dmareq_top u_dut (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
    .tx_single_req(ts), .tx_burst_req(tb), .rx_single_req(rs), .rx_burst_req(rb));

  dmareq_top #(.FIXED_LEVEL(1'b1)) u_fix (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
    .tx_single_req(fts), .tx_burst_req(ftb), .rx_single_req(frs), .rx_burst_req(frb));

  // {tx_count, rx_count, tx_en, rx_en, tx_sel, rx_sel, expected {ts,tb,rs,rb}}
  localparam logic [21:0] VEC [NV] = '{
    {5'd0,  5'd0,  1'b1, 1'b1, 3'd2, 3'd2, 4'b1100},
    {5'd16, 5'd16, 1'b1, 1'b1, 3'd2, 3'd2, 4'b0011},
    {5'd8,  5'd8,  1'b1, 1'b1, 3'd2, 3'd2, 4'b1111},
    {5'd9,  5'd7,  1'b1, 1'b1, 3'd2, 3'd2, 4'b1010},
    {5'd14, 5'd2,  1'b1, 1'b1, 3'd0, 3'd0, 4'b1111},
    {5'd15, 5'd1,  1'b1, 1'b1, 3'd0, 3'd0, 4'b1010},
    {5'd4,  5'd12, 1'b1, 1'b1, 3'd3, 3'd3, 4'b1111},
    {5'd2,  5'd13, 1'b1, 1'b1, 3'd4, 3'd4, 4'b1110},
    {5'd2,  5'd14, 1'b1, 1'b1, 3'd7, 3'd7, 4'b1111},
    {5'd3,  5'd15, 1'b1, 1'b1, 3'd5, 3'd6, 4'b1011},
    {5'd0,  5'd16, 1'b0, 1'b1, 3'd1, 3'd1, 4'b0011},
    {5'd0,  5'd16, 1'b1, 1'b0, 3'd1, 3'd1, 4'b1100},
    {5'd20, 5'd20, 1'b1, 1'b1, 3'd1, 3'd1, 4'b0011},
    {5'd12, 5'd4,  1'b1, 1'b1, 3'd1, 3'd1, 4'b1111},
    {5'd13, 5'd3,  1'b1, 1'b1, 3'd1, 3'd1, 4'b1010}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [21:0] v);
    tx_count    = v[21:17];
    rx_count    = v[16:12];
    tx_dma_en   = v[11];
    rx_dma_en   = v[10];
    tx_trig_sel = v[9:7];
    rx_trig_sel = v[6:4];
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: request-provoking inputs while reset is held
    @(negedge clk);
    drive({5'd0, 5'd16, 1'b1, 1'b1, 3'd1, 3'd1, 4'b0000});
    @(negedge clk);
    chk("R1 reset dut", {ts, tb, rs, rb}, 4'b0000);
    @(negedge clk);
    chk("R1 reset fixed", {fts, ftb, frs, frb}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 R5 after reset", {ts, tb, rs, rb}, 4'b1111);

    // R3 R4 R5 R6 R7 R9 R10: table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk($sformatf("R7 vector %0d", i), {ts, tb, rs, rb}, VEC[i][3:0]);
    end

    // R8: select 0 would give level 2; the fixed build stays at 4
    drive({5'd13, 5'd3, 1'b1, 1'b1, 3'd0, 3'd0, 4'b0000});
    @(negedge clk);
    chk("R7 level 2 at three", {ts, tb, rs, rb}, 4'b1111);
    chk("R8 fixed ignores select", {fts, ftb, frs, frb}, 4'b1010);
    drive({5'd12, 5'd4, 1'b1, 1'b1, 3'd4, 3'd4, 4'b0000});
    @(negedge clk);
    chk("R8 fixed at four", {fts, ftb, frs, frb}, 4'b1111);
    chk("R6 level 14 not reached", {ts, tb, rs, rb}, 4'b1010);

    // R2: new inputs not visible before the edge
    drive({5'd8, 5'd8, 1'b1, 1'b1, 3'd2, 3'd2, 4'b0000});
    #1;
    chk("R2 before edge", {ts, tb, rs, rb}, 4'b1010);
    @(negedge clk);
    chk("R2 after edge", {ts, tb, rs, rb}, 4'b1111);

    // R9: dropping one enable clears only that direction
    rx_dma_en = 1'b0;
    @(negedge clk);
    chk("R9 rx off", {ts, tb, rs, rb}, 4'b1100);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule